// File: doc/BRIEF.md
# Stage-2 Address Invalidation Translation Cache

This block is a small fully associative cache of second-stage address translations. Each entry holds one mapping from a guest intermediate page number to an output page number. Each entry also carries a mapping level, a virtual machine identifier and two tags: one says the entry holds a second-stage-only result, the other says it belongs to the guest kernel/user regime. Software-visible fills write an entry at a chosen slot. A combinational lookup port translates an intermediate page number for the current virtual machine.

The invalidate command carries a 32-bit operand. It removes every entry that meets all of these conditions: the entry is second-stage-only, it is tagged for the guest regime, its identifier equals the current one, and the operand's page falls inside the range the entry maps. A coarse block entry therefore matches any address inside its block. The command only acts while the non-secure state input is 1. Otherwise it completes as a no-op. The command affects this cache only.

A two-state controller acknowledges each command. State `ST_IDLE` moves to `ST_ACK` on a request (transition "accept"). `ST_ACK` stays in `ST_ACK` on a further request (transition "re-accept") and returns to `ST_IDLE` otherwise (transition "retire"). The done output is high exactly while the controller is in `ST_ACK`.

Top module: `s2tlb_inval`

## Requirements
- R1: After reset every entry is invalid, `inv_done` is 0 and every lookup misses.
- R2: A fill writes valid, tags, level, identifier, intermediate page and output page into slot `fill_idx` at the clock edge.
- R3: Lookup is combinational. It hits on the lowest-index valid entry whose identifier equals `cur_vmid` and whose range holds `lk_pn`. Tags do not affect lookup. The result page takes the entry's output page on the compared bits and `lk_pn` on the rest.
- R4: Level code 1 compares page bits [27:18], code 2 compares bits [27:9], and codes 3 and 0 compare all 28 bits. The same rule applies to lookup and to invalidation.
- R5: An invalidate request clears, at the edge where it is sampled, every valid entry that is stage-2-only, guest-regime, has identifier `cur_vmid` and whose range holds operand bits [27:0].
- R6: Operand bits [31:28] are reserved and have no effect on which entries are cleared.
- R7: With `ns_state` = 0 an invalidate leaves every entry unchanged, but it is still acknowledged.
- R8: Entries that are not stage-2-only, not guest-regime, or that carry another identifier survive an invalidate.
- R9: `inv_done` is high for exactly the cycle after each cycle in which `inv_req` is high. Back-to-back requests give back-to-back done cycles.
- R10: A lookup in the same cycle as an invalidate reports the contents from before the invalidate.
- R11: A fill in the same cycle as an invalidate is applied after it, so the filled entry is present even if it matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_vmid | input | VMID_W | Current virtual machine identifier |
| ns_state | input | 1 | Non-secure state; invalidation acts only when 1 |
| fill_valid | input | 1 | Write an entry this cycle |
| fill_idx | input | IDX_W | Slot to write |
| fill_s2only | input | 1 | Entry holds a stage-2-only result |
| fill_guest | input | 1 | Entry belongs to the guest kernel/user regime |
| fill_level | input | 2 | Mapping level code |
| fill_vmid | input | VMID_W | Entry identifier |
| fill_ipa_pn | input | 28 | Intermediate page number (address bits 39:12) |
| fill_pa_pn | input | 28 | Output page number |
| inv_req | input | 1 | Invalidate command strobe |
| inv_operand | input | 32 | Command operand; [27:0] page, [31:28] reserved |
| inv_done | output | 1 | One-cycle acknowledge |
| lk_pn | input | 28 | Lookup intermediate page number |
| lk_hit | output | 1 | Lookup hit |
| lk_pa_pn | output | 28 | Lookup output page number |

## Verification
The bench builds the block with its default of 8 entries and an 8-bit identifier. Eight slots are few enough that random fills soon leave several overlapping valid entries. A small identifier pool of four values and sparse page patterns that touch each level's compare field make block-range hits, identifier mismatches and lowest-index priority frequent. Directed cycles place an invalidate together with a fill to the same slot, together with a lookup, with reserved operand bits set, and with the non-secure input low.

// File: rtl/s2tlb_pkg.sv
package s2tlb_pkg;

    localparam int PN_W = 28;
    localparam int OP_W = 32;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_ACK  = 1'b1
    } inv_state_e;

    // compare mask over the page number for a level code
    function automatic logic [PN_W-1:0] level_mask(input logic [1:0] lvl);
        logic [PN_W-1:0] m;
        unique case (lvl)
            2'd1:    m = {{10{1'b1}}, {18{1'b0}}};
            2'd2:    m = {{19{1'b1}}, {9{1'b0}}};
            default: m = {PN_W{1'b1}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/s2tlb_inv_fsm.sv
module s2tlb_inv_fsm
    import s2tlb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inv_req,
    output logic inv_done
);

    inv_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (inv_req) state_d = ST_ACK;     // accept
            ST_ACK:  state_d = inv_req ? ST_ACK         // re-accept
                                       : ST_IDLE;       // retire
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        inv_done = 1'b0;
        unique case (state_q)
            ST_IDLE: inv_done = 1'b0;
            ST_ACK:  inv_done = 1'b1;
            default: inv_done = 1'b0;
        endcase
    end

    // R9
    done_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |=> inv_done);
    // R9
    done_only_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_req |=> !inv_done);

endmodule

// File: rtl/s2tlb_entry_cmp.sv
module s2tlb_entry_cmp
    import s2tlb_pkg::*;
#(
    parameter int VMID_W = 8
) (
    input  logic              e_valid,
    input  logic              e_s2only,
    input  logic              e_guest,
    input  logic [1:0]        e_level,
    input  logic [VMID_W-1:0] e_vmid,
    input  logic [PN_W-1:0]   e_ipa,
    input  logic [VMID_W-1:0] cur_vmid,
    input  logic [PN_W-1:0]   inv_pn,
    input  logic [PN_W-1:0]   lk_pn,
    output logic              inv_hit,
    output logic              lk_hit
);

    logic [PN_W-1:0] mask;
    logic            vmid_eq;

    always_comb begin
        mask    = level_mask(e_level);
        vmid_eq = (e_vmid == cur_vmid);
        inv_hit = e_valid && e_s2only && e_guest && vmid_eq
                  && (((e_ipa ^ inv_pn) & mask) == '0);
        lk_hit  = e_valid && vmid_eq && (((e_ipa ^ lk_pn) & mask) == '0);
    end

endmodule

// File: rtl/s2tlb_inval.sv
module s2tlb_inval
    import s2tlb_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int VMID_W    = 8,
    localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VMID_W-1:0] cur_vmid,
    input  logic              ns_state,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic              fill_s2only,
    input  logic              fill_guest,
    input  logic [1:0]        fill_level,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic [PN_W-1:0]   fill_ipa_pn,
    input  logic [PN_W-1:0]   fill_pa_pn,
    input  logic              inv_req,
    input  logic [OP_W-1:0]   inv_operand,
    output logic              inv_done,
    input  logic [PN_W-1:0]   lk_pn,
    output logic              lk_hit,
    output logic [PN_W-1:0]   lk_pa_pn
);

    logic [N_ENTRIES-1:0] valid_q;
    logic [N_ENTRIES-1:0] s2only_q;
    logic [N_ENTRIES-1:0] guest_q;
    logic [1:0]           level_q [N_ENTRIES];
    logic [VMID_W-1:0]    vmid_q  [N_ENTRIES];
    logic [PN_W-1:0]      ipa_q   [N_ENTRIES];
    logic [PN_W-1:0]      pa_q    [N_ENTRIES];

    logic [N_ENTRIES-1:0] inv_hit;
    logic [N_ENTRIES-1:0] lk_hit_v;
    logic [PN_W-1:0]      inv_pn;
    logic                 inv_fire;

    assign inv_pn   = inv_operand[PN_W-1:0];   // reserved upper bits dropped
    assign inv_fire = inv_req && ns_state;

    s2tlb_inv_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .inv_req  (inv_req),
        .inv_done (inv_done)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
        s2tlb_entry_cmp #(.VMID_W(VMID_W)) u_cmp (
            .e_valid  (valid_q[g]),
            .e_s2only (s2only_q[g]),
            .e_guest  (guest_q[g]),
            .e_level  (level_q[g]),
            .e_vmid   (vmid_q[g]),
            .e_ipa    (ipa_q[g]),
            .cur_vmid (cur_vmid),
            .inv_pn   (inv_pn),
            .lk_pn    (lk_pn),
            .inv_hit  (inv_hit[g]),
            .lk_hit   (lk_hit_v[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g]  <= 1'b0;
                s2only_q[g] <= 1'b0;
                guest_q[g]  <= 1'b0;
                level_q[g]  <= '0;
                vmid_q[g]   <= '0;
                ipa_q[g]    <= '0;
                pa_q[g]     <= '0;
            end else if (fill_valid && (fill_idx == IDX_W'(g))) begin
                // fill ordered after any coincident invalidate
                valid_q[g]  <= 1'b1;
                s2only_q[g] <= fill_s2only;
                guest_q[g]  <= fill_guest;
                level_q[g]  <= fill_level;
                vmid_q[g]   <= fill_vmid;
                ipa_q[g]    <= fill_ipa_pn;
                pa_q[g]     <= fill_pa_pn;
            end else if (inv_fire && inv_hit[g]) begin
                valid_q[g]  <= 1'b0;
            end
        end
    end

    // lowest index wins
    always_comb begin
        lk_hit   = 1'b0;
        lk_pa_pn = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (lk_hit_v[i]) begin
                lk_hit   = 1'b1;
                lk_pa_pn = (pa_q[i] & level_mask(level_q[i]))
                         | (lk_pn & ~level_mask(level_q[i]));
            end
        end
    end

    // R7
    ns_low_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_req && !ns_state && !fill_valid) |=> (valid_q == $past(valid_q)));
    // R5
    inv_never_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_valid) |=> ((valid_q & ~$past(valid_q)) == '0));
    // R11
    fill_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> valid_q[$past(fill_idx)]);
    // R3
    lk_hit_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (valid_q != '0));

endmodule

// File: tb/s2tlb_inval_tb.sv
module s2tlb_inval_tb;
    localparam int N  = 8;
    localparam int VW = 8;
    localparam int IW = 3;
    localparam int PW = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] cur_vmid = '0;
    logic          ns_state = 1'b1;
    logic          fill_valid = 1'b0;
    logic [IW-1:0] fill_idx = '0;
    logic          fill_s2only = 1'b0, fill_guest = 1'b0;
    logic [1:0]    fill_level = '0;
    logic [VW-1:0] fill_vmid = '0;
    logic [PW-1:0] fill_ipa_pn = '0, fill_pa_pn = '0;
    logic          inv_req = 1'b0;
    logic [31:0]   inv_operand = '0;
    logic          inv_done;
    logic [PW-1:0] lk_pn = '0;
    logic          lk_hit;
    logic [PW-1:0] lk_pa_pn;

    always #2.5 clk = ~clk;

    s2tlb_inval #(.N_ENTRIES(N), .VMID_W(VW)) u_dut (.*);

    int n_tests = 0, n_fail = 0;

    // reference state
    logic          m_v [N];
    logic          m_s2[N];
    logic          m_g [N];
    logic [1:0]    m_l [N];
    logic [VW-1:0] m_vm[N];
    logic [PW-1:0] m_ip[N];
    logic [PW-1:0] m_pa[N];
    logic          exp_done = 1'b0;

    function automatic logic [PW-1:0] mk(input logic [1:0] l);
        if (l == 2'd1) return {{10{1'b1}}, {18{1'b0}}};
        if (l == 2'd2) return {{19{1'b1}}, {9{1'b0}}};
        return {PW{1'b1}};
    endfunction

    function automatic logic [PW:0] ref_lookup(input logic [PW-1:0] pn, input logic [VW-1:0] vm);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vm[i] == vm && ((m_ip[i] ^ pn) & mk(m_l[i])) == '0)
                return {1'b1, (m_pa[i] & mk(m_l[i])) | (pn & ~mk(m_l[i]))};
        return '0;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: inputs already set by caller; called just after a negedge
    task automatic step(input string req);
        logic [PW:0] r;
        #1;
        r = ref_lookup(lk_pn, cur_vmid);
        check({req, " R3 R10 lookup"}, {35'd0, lk_hit, lk_pa_pn}, {35'd0, r});
        if (inv_req && ns_state)
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_s2[i] && m_g[i] && m_vm[i] == cur_vmid
                    && ((m_ip[i] ^ inv_operand[PW-1:0]) & mk(m_l[i])) == '0)
                    m_v[i] = 1'b0;
        if (fill_valid) begin
            m_v[fill_idx] = 1'b1; m_s2[fill_idx] = fill_s2only; m_g[fill_idx] = fill_guest;
            m_l[fill_idx] = fill_level; m_vm[fill_idx] = fill_vmid;
            m_ip[fill_idx] = fill_ipa_pn; m_pa[fill_idx] = fill_pa_pn;
        end
        exp_done = inv_req;
        @(negedge clk);
        check("R9 done", {63'd0, inv_done}, {63'd0, exp_done});
        fill_valid = 1'b0;
        inv_req = 1'b0;
    endtask

    task automatic do_fill(input int idx, input logic s2, input logic g, input logic [1:0] l,
                           input logic [VW-1:0] vm, input logic [PW-1:0] ip, input logic [PW-1:0] pa);
        fill_valid = 1'b1; fill_idx = IW'(idx); fill_s2only = s2; fill_guest = g;
        fill_level = l; fill_vmid = vm; fill_ipa_pn = ip; fill_pa_pn = pa;
    endtask

    // probe a page through the lookup port with a chosen vmid
    task automatic probe(input string req, input logic [PW-1:0] pn, input logic [VW-1:0] vm);
        cur_vmid = vm; lk_pn = pn;
        step(req);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_s2[i] = 0; m_g[i] = 0; m_l[i] = 0; m_vm[i] = 0; m_ip[i] = 0; m_pa[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 done", {63'd0, inv_done}, 64'd0);
        lk_pn = 28'h1234567; #1;
        check("R1 lookup", {63'd0, lk_hit}, 64'd0);

        // R2 R4 level-1 block entry, lookup inside block
        do_fill(0, 1, 1, 2'd1, 8'd5, 28'hAC00000, 28'h3C00000);
        step("R2 fill");
        probe("R2 R4 block", 28'hAC3FFFF, 8'd5);
        // R8 entries surviving: wrong vmid, not s2only, not guest
        do_fill(1, 1, 1, 2'd3, 8'd6, 28'h0000123, 28'h0000777); step("R2");
        do_fill(2, 0, 1, 2'd3, 8'd5, 28'h0000123, 28'h0000888); step("R2");
        do_fill(3, 1, 0, 2'd2, 8'd5, 28'h0000000, 28'h0001000); step("R2");
        // R6 reserved bits set, address inside level-1 block of entry 0
        cur_vmid = 8'd5; inv_req = 1'b1; inv_operand = {4'hF, 28'hAC12345};
        step("R5 R6 inv block");
        probe("R5 block gone", 28'hAC00000, 8'd5);
        inv_req = 1'b1; inv_operand = {4'hA, 28'h0000123}; step("R8 inv");
        probe("R8 s2only0 survives", 28'h0000123, 8'd5);
        probe("R8 vmid survives", 28'h0000123, 8'd6);
        cur_vmid = 8'd5; inv_req = 1'b1; inv_operand = 32'h0000_0100; step("R8 inv");
        probe("R8 guest0 survives", 28'h00001FF, 8'd5);
        // R7 ns low
        do_fill(4, 1, 1, 2'd3, 8'd5, 28'h0BEEF00, 28'h0CAFE00); step("R2");
        ns_state = 1'b0; inv_req = 1'b1; inv_operand = 32'h0BEEF00; step("R7 ns0");
        ns_state = 1'b1;
        probe("R7 kept", 28'h0BEEF00, 8'd5);
        // R10 lookup in same cycle as invalidate sees old; R9 back-to-back
        inv_req = 1'b1; inv_operand = 32'h0BEEF00; lk_pn = 28'h0BEEF00; step("R10 same cycle");
        inv_req = 1'b1; inv_operand = 32'h0BEEF00; step("R9 back-to-back");
        probe("R5 gone", 28'h0BEEF00, 8'd5);
        // R11 fill collides with matching invalidate
        do_fill(5, 1, 1, 2'd3, 8'd5, 28'h0ABC000, 28'h0111000);
        inv_req = 1'b1; inv_operand = 32'h0ABC000; step("R11 collide");
        probe("R11 kept", 28'h0ABC000, 8'd5);

        // random phase
        for (int k = 0; k < 3000; k++) begin
            int op;
            op = $urandom % 4;
            cur_vmid = VW'($urandom % 4);
            ns_state = ($urandom % 8) != 0;
            lk_pn = PW'($urandom) & 28'hC000603;
            if (op == 0 || op == 3)
                do_fill($urandom % N, $urandom % 4 != 0, $urandom % 4 != 0, 2'($urandom),
                        VW'($urandom % 4), PW'($urandom) & 28'hC000603, PW'($urandom));
            if (op == 1 || op == 3) begin
                inv_req = 1'b1;
                inv_operand = {4'($urandom), PW'($urandom) & 28'hC000603};
            end
            step("R3 R5 R8 R10 R11 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule